// File: doc/BRIEF.md
# Compressed Reciprocal-Ratio Lookup

This block turns an 8-bit index `z` (0 to 255) into an 8-bit weight close to 256·(1 − z/(z+1)), that is, roughly 256/(z+1). A flat 256-byte table is not stored. Each result is built from three small pieces. A 16-entry direct table covers the steep start of the curve. A 32-entry table holds one floor value for each 8-wide range of `z`. A 32-entry table holds one step mask per range, and each set bit in the mask marks an index where the curve drops by one. The number of drops still ahead of `z` inside its range is found by shifting the mask left by the low three bits of `z` and counting the ones that remain.

A caller presents `z` with a valid strobe. The weight comes out of a register `LAT` cycles later (1 or 2, chosen by parameter) together with a matching valid. While no valid input reaches the output register, the output holds its last weight.

Top module: `ratio_lut_top`

## Requirements
- R1: For z ≥ 16, with range r = z[7:3] and offset k = z[2:0], the output equals floor[r] + popcount((mask[r] << k) truncated to 8 bits), taken modulo 256. The floors for r = 0..31 are 0,0,11,8,6,5,5,4,4,3,3,3,2,2,2,2,2,2,2,2,2,1,1,1,1,1,1,1,1,1,1,0. The masks in hex are 00,00,D4,44,42,04,00,00,00,80,00,00,04,00,00,00,00,00,00,00,00,40,00,00,00,00,00,00,00,00,00,02. As a result every output for z ≥ 16 is at most 15.
- R2: For z < 16 the output is the direct entry for z, in order 255,128,85,64,51,43,37,32,28,26,23,21,20,18,17,16. The direct table adds nothing for z ≥ 16, and every output for z < 16 is at least 16.
- R3: z = 0 gives 255 and z = 255 gives 0.
- R4: Mask bits shifted past bit 7 are dropped, not carried: z = 23 gives 11 and z = 255 gives 0.
- R5: Over z = 0..255 the output never increases as z increases.
- R6: `out_valid` equals `in_valid` delayed by exactly `LAT` clock cycles (LAT = 1 or 2). Back-to-back inputs give back-to-back results.
- R7: In any cycle where `out_valid` is low, `out_val` keeps its previous value, whatever `in_z` carries.
- R8: After a cycle with `rst_n` low, `out_valid` is 0 and `out_val` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Qualifies `in_z` this cycle |
| in_z | input | 8 | Index to convert |
| out_valid | output | 1 | `out_val` holds a fresh result |
| out_val | output | 8 | Reconstructed weight |

## Verification
The assertions check four things on every cycle. The first is the valid latency. The second is that the output holds while no result arrives. The third is the reset state. The fourth is a set of coarse value bounds: both endpoints, outputs of at least 16 below z = 16, and outputs of at most 15 from 16 on. The exact value of each of the 256 entries, the dropping of mask bits past bit 7, and the non-increasing shape of the curve can only be shown by the bench. It sweeps every index and runs a random stream of mixed valid and idle cycles, and compares each result with its own reference sum.

// File: rtl/ratio_lut_pkg.sv
// ratio_lut_pkg
// Widths and the three compressed tables for the reciprocal-ratio lookup.
// Assumes an 8-bit index split into a 5-bit range and a 3-bit offset.
package ratio_lut_pkg;

    localparam int IDX_W    = 8;                    // index width
    localparam int LO_W     = 3;                    // offset bits inside a range
    localparam int HI_W     = IDX_W - LO_W;         // range-select bits
    localparam int RANGES   = 1 << HI_W;            // number of ranges
    localparam int SPAN     = 1 << LO_W;            // indices per range
    localparam int DIRECT_N = 16;                   // entries served by the direct table
    localparam int DIRECT_W = $clog2(DIRECT_N);     // direct-table address width
    localparam int VAL_W    = 8;                    // output width
    localparam int CNT_W    = $clog2(SPAN + 1);     // popcount width

    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [VAL_W-1:0]  val_t;
    typedef logic [SPAN-1:0]   mask_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    // Direct values for the first DIRECT_N indices.
    function automatic val_t direct_val(input logic [DIRECT_W-1:0] a);
        case (a)
            4'd0:  return 8'd255;
            4'd1:  return 8'd128;
            4'd2:  return 8'd85;
            4'd3:  return 8'd64;
            4'd4:  return 8'd51;
            4'd5:  return 8'd43;
            4'd6:  return 8'd37;
            4'd7:  return 8'd32;
            4'd8:  return 8'd28;
            4'd9:  return 8'd26;
            4'd10: return 8'd23;
            4'd11: return 8'd21;
            4'd12: return 8'd20;
            4'd13: return 8'd18;
            4'd14: return 8'd17;
            default: return 8'd16;
        endcase
    endfunction

    // Smallest value reached inside each range (zero for the direct-covered ranges).
    function automatic val_t range_floor(input logic [HI_W-1:0] r);
        case (r)
            5'd2:  return 8'd11;
            5'd3:  return 8'd8;
            5'd4, 5'd5, 5'd6: return (r == 5'd4) ? 8'd6 : 8'd5;
            5'd7, 5'd8:  return 8'd4;
            5'd9, 5'd10, 5'd11: return 8'd3;
            5'd12, 5'd13, 5'd14, 5'd15, 5'd16,
            5'd17, 5'd18, 5'd19, 5'd20: return 8'd2;
            5'd21, 5'd22, 5'd23, 5'd24, 5'd25,
            5'd26, 5'd27, 5'd28, 5'd29, 5'd30: return 8'd1;
            default: return 8'd0;
        endcase
    endfunction

    // Step mask per range: a set bit marks a drop by one at that offset.
    function automatic mask_t step_mask(input logic [HI_W-1:0] r);
        case (r)
            5'd2:  return 8'hD4;
            5'd3:  return 8'h44;
            5'd4:  return 8'h42;
            5'd5:  return 8'h04;
            5'd9:  return 8'h80;
            5'd12: return 8'h04;
            5'd21: return 8'h40;
            5'd31: return 8'h02;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/ratio_direct_tbl.sv
// ratio_direct_tbl
// Returns the direct-table value for small indices and zero otherwise.
// Purely combinational; assumes the caller registers the result.
module ratio_direct_tbl
    import ratio_lut_pkg::*;
(
    input  logic [IDX_W-1:0] z,
    output logic [VAL_W-1:0] base
);

    logic in_window;

    // Flag indices that the direct table covers.
    always_comb in_window = (z < IDX_W'(DIRECT_N));

    // Pick the entry or contribute nothing.
    always_comb base = in_window ? direct_val(z[DIRECT_W-1:0]) : '0;

endmodule

// File: rtl/ratio_range_step.sv
// ratio_range_step
// Looks up the floor and step mask of the range holding z, drops the
// steps already passed by shifting the mask left by the offset (bits
// leaving the field are lost), and counts the steps still ahead.
// Purely combinational.
module ratio_range_step
    import ratio_lut_pkg::*;
(
    input  logic [IDX_W-1:0] z,
    output logic [VAL_W-1:0] floor_o,
    output logic [CNT_W-1:0] steps_o
);

    logic [HI_W-1:0] sel;
    logic [LO_W-1:0] off;
    mask_t           raw;
    mask_t           kept;
    cnt_t            lane_cnt [SPAN];

    // Split the index into range and offset.
    always_comb begin
        sel = z[IDX_W-1:LO_W];
        off = z[LO_W-1:0];
    end

    // Fetch the range constants.
    always_comb begin
        floor_o = range_floor(sel);
        raw     = step_mask(sel);
    end

    // Shift inside the mask width so upper bits fall off.
    always_comb kept = raw << off;

    // Ripple popcount across the mask lanes.
    genvar lane;
    generate
        for (lane = 0; lane < SPAN; lane++) begin : g_cnt
            if (lane == 0) begin : g_first
                assign lane_cnt[lane] = cnt_t'(kept[lane]);
            end else begin : g_rest
                assign lane_cnt[lane] = lane_cnt[lane-1] + cnt_t'(kept[lane]);
            end
        end
    endgenerate

    // Final count leaves the module.
    always_comb steps_o = lane_cnt[SPAN-1];

endmodule

// File: rtl/ratio_lut_top.sv
// ratio_lut_top
// Index-to-weight lookup rebuilt from a direct table, range floors and
// popcounted step masks. LAT = 2 registers the three parts before the
// add; any other value gives a single output register (latency 1).
// Data registers load only on valid; valid flows every cycle.
// Synchronous active-low reset.
module ratio_lut_top
    import ratio_lut_pkg::*;
#(
    parameter int LAT = 2
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [IDX_W-1:0] in_z,
    output logic             out_valid,
    output logic [VAL_W-1:0] out_val
);

    localparam bit SPLIT = (LAT == 2);

    logic [VAL_W-1:0] base_c;
    logic [VAL_W-1:0] floor_c;
    logic [CNT_W-1:0] steps_c;

    ratio_direct_tbl u_direct (
        .z    (in_z),
        .base (base_c)
    );

    ratio_range_step u_range (
        .z       (in_z),
        .floor_o (floor_c),
        .steps_o (steps_c)
    );

    generate
        if (SPLIT) begin : g_two
            logic             mid_valid;
            logic [VAL_W-1:0] mid_base;
            logic [VAL_W-1:0] mid_floor;
            logic [CNT_W-1:0] mid_steps;
            logic [VAL_W-1:0] sum_c;

            // Stage 1: capture the three parts.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    mid_valid <= 1'b0;
                    mid_base  <= '0;
                    mid_floor <= '0;
                    mid_steps <= '0;
                end else begin
                    mid_valid <= in_valid;
                    if (in_valid) begin
                        mid_base  <= base_c;
                        mid_floor <= floor_c;
                        mid_steps <= steps_c;
                    end
                end
            end

            // Add the parts modulo 2^VAL_W.
            always_comb sum_c = mid_base + mid_floor + VAL_W'(mid_steps);

            // Stage 2: output register.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    out_valid <= 1'b0;
                    out_val   <= '0;
                end else begin
                    out_valid <= mid_valid;
                    if (mid_valid) out_val <= sum_c;
                end
            end
        end else begin : g_one
            logic [VAL_W-1:0] sum_c;

            // Add the parts straight from the tables.
            always_comb sum_c = base_c + floor_c + VAL_W'(steps_c);

            // Single output register.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    out_valid <= 1'b0;
                    out_val   <= '0;
                end else begin
                    out_valid <= in_valid;
                    if (in_valid) out_val <= sum_c;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/ratio_lut_chk.sv
// ratio_lut_chk
// Protocol and bound checks for ratio_lut_top, attached by bind.
// Tracks its own delayed copy of the valid strobe and index.
module ratio_lut_chk
    import ratio_lut_pkg::*;
#(
    parameter int LAT = 2
)(
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [IDX_W-1:0] in_z,
    input logic             out_valid,
    input logic [VAL_W-1:0] out_val
);

    localparam int D = (LAT == 2) ? 2 : 1;

    logic [D-1:0]     vq;
    logic [IDX_W-1:0] zq [D];
    logic [IDX_W-1:0] zo;

    // Shadow pipeline of valid and index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vq <= '0;
            for (int k = 0; k < D; k++) zq[k] <= '0;
        end else begin
            vq[0] <= in_valid;
            if (in_valid) zq[0] <= in_z;
            for (int k = 1; k < D; k++) begin
                vq[k] <= vq[k-1];
                if (vq[k-1]) zq[k] <= zq[k-1];
            end
        end
    end

    // Index that the present output belongs to.
    always_comb zo = zq[D-1];

    p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == vq[D-1]);

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_val));

    p_reset_r8: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_val == '0));

    p_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && zo == 8'd0) |-> out_val == 8'd255);

    p_bottom_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && zo == 8'd255) |-> out_val == 8'd0);

    p_direct_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && zo < 8'd16) |-> out_val >= 8'd16);

    p_tail_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && zo >= 8'd16) |-> out_val <= 8'd15);

endmodule

bind ratio_lut_top ratio_lut_chk #(.LAT(LAT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_z      (in_z),
    .out_valid (out_valid),
    .out_val   (out_val)
);

// File: tb/sim_ratio_lut_top.sv
module sim_ratio_lut_top;

    localparam int LAT = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_z = 8'd0;
    logic       out_valid;
    logic [7:0] out_val;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ratio_lut_top #(.LAT(LAT)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_z(in_z),
        .out_valid(out_valid), .out_val(out_val)
    );

    // Reference: direct part + floor + remaining steps, from the requirement lists.
    function automatic logic [7:0] model(input logic [7:0] z);
        logic [7:0] dl [16] = '{255,128,85,64,51,43,37,32,28,26,23,21,20,18,17,16};
        logic [7:0] fl [32] = '{0,0,11,8,6,5,5,4,4,3,3,3,2,2,2,2,
                                2,2,2,2,2,1,1,1,1,1,1,1,1,1,1,0};
        logic [7:0] mk [32] = '{8'h00,8'h00,8'hD4,8'h44,8'h42,8'h04,8'h00,8'h00,
                                8'h00,8'h80,8'h00,8'h00,8'h04,8'h00,8'h00,8'h00,
                                8'h00,8'h00,8'h00,8'h00,8'h00,8'h40,8'h00,8'h00,
                                8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h02};
        logic [7:0] m;
        logic [7:0] d;
        m = mk[z[7:3]] << z[2:0];
        d = (z < 8'd16) ? dl[z[3:0]] : 8'd0;
        return d + fl[z[7:3]] + 8'($countones(m));
    endfunction

    task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One isolated lookup; returns output sampled LAT cycles later.
    task automatic lookup(input logic [7:0] z, output logic [7:0] v, output logic vld);
        @(negedge clk);
        in_valid = 1'b1;
        in_z = z;
        @(negedge clk);
        in_valid = 1'b0;
        in_z = ~z;
        repeat (LAT - 1) @(negedge clk);
        v = out_val;
        vld = out_valid;
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                checks++;
                errors++;
                $display("FAIL watchdog R6 actual=%0d expected=%0d", cyc, 100000);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        logic [7:0] v;
        logic       vld;
        logic [7:0] prev;
        logic [7:0] held;
        logic       hv [4];
        logic [7:0] hz [4];

        repeat (3) @(negedge clk);
        // R8: reset state
        chk("R8 valid", 9'(out_valid), 9'd0);
        chk("R8 value", 9'(out_val), 9'd0);
        rst_n = 1'b1;

        // Directed corners
        lookup(8'd0, v, vld);
        chk("R3 z=0", 9'(v), 9'd255);
        chk("R6 valid", 9'(vld), 9'd1);
        lookup(8'd255, v, vld);
        chk("R3/R4 z=255", 9'(v), 9'd0);
        lookup(8'd23, v, vld);
        chk("R4 z=23", 9'(v), 9'd11);
        lookup(8'd16, v, vld);
        chk("R1 z=16", 9'(v), 9'd15);
        lookup(8'd15, v, vld);
        chk("R2 z=15", 9'(v), 9'd16);

        // R7: idle cycles with changing index do not move the output
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            in_z = 8'(i * 37);
            chk("R7 hold", 9'(out_val), 9'd16);
            chk("R7 valid low", 9'(out_valid), 9'd0);
        end

        // Full sweep: R1, R2 exact values; R5 non-increasing
        prev = 8'd255;
        for (int z = 0; z < 256; z++) begin
            lookup(8'(z), v, vld);
            chk(z < 16 ? "R2 sweep" : "R1 sweep", 9'(v), 9'(model(8'(z))));
            if (z > 0) chk("R5 monotone", 9'(v > prev), 9'd0);
            prev = v;
        end

        // Random stream, fixed seed: R6 latency, R7 hold, R1 values
        void'($urandom(32'd1234));
        for (int k = 0; k < 4; k++) begin hv[k] = 1'b0; hz[k] = 8'd0; end
        @(negedge clk);
        held = out_val;
        for (int n = 0; n < 2000; n++) begin
            chk("R6 stream valid", 9'(out_valid), 9'(hv[LAT-1]));
            if (hv[LAT-1]) held = model(hz[LAT-1]);
            chk(hv[LAT-1] ? "R1 stream value" : "R7 stream hold", 9'(out_val), 9'(held));
            for (int k = 3; k > 0; k--) begin hv[k] = hv[k-1]; hz[k] = hz[k-1]; end
            in_valid = ($urandom % 3) != 0;
            in_z = 8'($urandom);
            hv[0] = in_valid;
            hz[0] = in_z;
            @(negedge clk);
        end

        in_valid = 1'b0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        done = 1'b1;
        $finish;
    end

endmodule